// File: doc/BRIEF.md
# Sound Generator Host Bus Register Front End

This block sits between a host bus and the sixteen control registers of a three-channel sound generator. Three strobe lines choose what each bus cycle does. A cycle can be idle, capture a register index, store a data byte or return a data byte. An index is captured only when the upper data bits match a configured pattern and every chip-enable pin is at its active level. Once an index is captured, data cycles act on that register until the next capture attempt.

Parameters cover the different packagings of the part. A pin that a packaging lacks is taken as held at a fixed level. The polarity of one enable pin can be chosen, and so can the upper-bit pattern. One packaging option lets the test enable pin also turn the read driver off. Reads are combinational. The output enable is a separate signal, and the data output is zero whenever the enable is low. Reset is synchronous and active high.

Top module: `psg_bus_front`

## Requirements
- R1: The code {bdir,bc2,bc1} selects the operation: 3'b111 captures an index, 3'b110 writes, 3'b011 reads. Every other code is idle: it changes no state and leaves `d_oe` low.
- R2: A capture succeeds only when all of these hold: `a9_n` is low, `a8` is at its active level, `test2` is high, and `d_in[7:4]` equals `SEL_PATTERN`. On success, `d_in[3:0]` becomes the register index.
- R3: `SEL_PATTERN` (default 0) sets the upper-bit pattern. `A8_ACTIVE_HIGH` (default 1) sets the active level of `a8`.
- R4: A failed capture deselects the block. Writes and reads then do nothing until a later capture succeeds.
- R5: A write cycle while selected stores `d_in` into the indexed register at the clock edge.
- R6: A read cycle while selected raises `d_oe` in the same cycle and drives the indexed register on `d_out`. In all other cases `d_oe` is low and `d_out` is zero.
- R7: With `TEST2_GATES_BUS`=1, `d_oe` stays low whenever `test2` is low.
- R8: With `HAS_BC2`=0, the `bc2` pin is ignored and treated as 1. The codes become {bdir,bc1}: 2'b11 captures, 2'b10 writes, 2'b01 reads.
- R9: With `HAS_A9`=0, `a9_n` is ignored and treated as low. With `HAS_TEST2`=0, `test2` is ignored and treated as high.
- R10: Reset clears all sixteen registers, the index and the selected state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bdir | input | 1 | Bus direction strobe |
| bc2 | input | 1 | Bus control strobe 2 |
| bc1 | input | 1 | Bus control strobe 1 |
| a9_n | input | 1 | Active-low chip enable |
| a8 | input | 1 | Chip enable, polarity set by parameter |
| test2 | input | 1 | Active-high chip enable |
| d_in | input | DATA_W | Bus data in (index or write data) |
| d_out | output | DATA_W | Read data, zero when not enabled |
| d_oe | output | 1 | Read data output enable |

## Verification
The main instance is built with the pattern 4'hF, an active-low `a8` and read gating by `test2`. This exercises a non-zero pattern, the inverted polarity and the bus-disable path against a cycle-level model. A second instance is built without the `bc2`, `a9_n` and `test2` pins and with the default pattern and polarity. It shows that the missing pins are ignored even when driven to their inactive levels, and that the reduced two-bit strobe code decodes correctly.

// File: rtl/psg_bus_pkg.sv
package psg_bus_pkg;
   typedef enum logic [1:0] {
      BUS_IDLE  = 2'd0,
      BUS_LATCH = 2'd1,
      BUS_WRITE = 2'd2,
      BUS_READ  = 2'd3
   } bus_op_e;

   function automatic bus_op_e decode_strobes(input logic bdir, input logic bc2, input logic bc1);
      case ({bdir, bc2, bc1})
         3'b111:  return BUS_LATCH;
         3'b110:  return BUS_WRITE;
         3'b011:  return BUS_READ;
         default: return BUS_IDLE;
      endcase
   endfunction
endpackage

// File: rtl/psg_strobe_decode.sv
module psg_strobe_decode
   import psg_bus_pkg::*;
#(
   parameter bit HAS_BC2 = 1'b1
) (
   input  logic    bdir,
   input  logic    bc2,
   input  logic    bc1,
   output bus_op_e op
);
   logic bc2_eff;

   generate
      if (HAS_BC2) begin : g_bc2_pin
         assign bc2_eff = bc2;
      end else begin : g_bc2_tied
         logic unused_bc2;
         assign unused_bc2 = bc2;
         assign bc2_eff    = 1'b1;
      end
   endgenerate

   assign op = decode_strobes(bdir, bc2_eff, bc1);
endmodule

// File: rtl/psg_chip_enable.sv
module psg_chip_enable #(
   parameter bit HAS_A9         = 1'b1,
   parameter bit HAS_TEST2      = 1'b1,
   parameter bit A8_ACTIVE_HIGH = 1'b1
) (
   input  logic a9_n,
   input  logic a8,
   input  logic test2,
   output logic enabled,
   output logic test2_eff
);
   logic a9_ok;
   logic a8_ok;

   generate
      if (HAS_A9) begin : g_a9_pin
         assign a9_ok = ~a9_n;
      end else begin : g_a9_tied
         logic unused_a9;
         assign unused_a9 = a9_n;
         assign a9_ok     = 1'b1;
      end

      if (HAS_TEST2) begin : g_t2_pin
         assign test2_eff = test2;
      end else begin : g_t2_tied
         logic unused_t2;
         assign unused_t2 = test2;
         assign test2_eff = 1'b1;
      end

      if (A8_ACTIVE_HIGH) begin : g_a8_high
         assign a8_ok = a8;
      end else begin : g_a8_low
         assign a8_ok = ~a8;
      end
   endgenerate

   assign enabled = a9_ok & a8_ok & test2_eff;
endmodule

// File: rtl/psg_reg_bank.sv
module psg_reg_bank #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned IDX_W  = 4,
   localparam int unsigned NREG  = 1 << IDX_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] regs [NREG];

   generate
      for (genvar i = 0; i < NREG; i++) begin : g_entry
         always_ff @(posedge clk) begin
            if (rst) begin
               regs[i] <= '0;
            end else if (we && (idx == IDX_W'(i))) begin
               regs[i] <= wdata;
            end
         end
      end
   endgenerate

   assign rdata = regs[idx];
endmodule

// File: rtl/psg_bus_front.sv
module psg_bus_front
   import psg_bus_pkg::*;
#(
   parameter int unsigned DATA_W          = 8,
   parameter int unsigned IDX_W           = 4,
   parameter int unsigned SEL_PATTERN     = 0,
   parameter bit          A8_ACTIVE_HIGH  = 1'b1,
   parameter bit          HAS_BC2         = 1'b1,
   parameter bit          HAS_A9          = 1'b1,
   parameter bit          HAS_TEST2       = 1'b1,
   parameter bit          TEST2_GATES_BUS = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bdir,
   input  logic              bc2,
   input  logic              bc1,
   input  logic              a9_n,
   input  logic              a8,
   input  logic              test2,
   input  logic [DATA_W-1:0] d_in,
   output logic [DATA_W-1:0] d_out,
   output logic              d_oe
);
   localparam int unsigned PAT_W = DATA_W - IDX_W;

   generate
      if (IDX_W < 1 || IDX_W >= DATA_W) begin : g_bad_idx
         $error("psg_bus_front: IDX_W must lie between 1 and DATA_W-1");
      end
      if (PAT_W < 32 && SEL_PATTERN >= (1 << PAT_W)) begin : g_bad_pat
         $error("psg_bus_front: SEL_PATTERN does not fit above the index bits");
      end
   endgenerate

   bus_op_e           op;
   logic              enabled;
   logic              test2_eff;
   logic              match;
   logic              sel_q;
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] rdata;
   logic              bus_allowed;

   psg_strobe_decode #(.HAS_BC2(HAS_BC2)) u_dec (
      .bdir(bdir), .bc2(bc2), .bc1(bc1), .op(op)
   );

   psg_chip_enable #(
      .HAS_A9(HAS_A9), .HAS_TEST2(HAS_TEST2), .A8_ACTIVE_HIGH(A8_ACTIVE_HIGH)
   ) u_en (
      .a9_n(a9_n), .a8(a8), .test2(test2), .enabled(enabled), .test2_eff(test2_eff)
   );

   assign match = enabled && (d_in[DATA_W-1:IDX_W] == SEL_PATTERN[PAT_W-1:0]);

   always_ff @(posedge clk) begin
      if (rst) begin
         sel_q <= 1'b0;
         idx_q <= '0;
      end else if (op == BUS_LATCH) begin
         sel_q <= match;
         if (match) idx_q <= d_in[IDX_W-1:0];
      end
   end

   psg_reg_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
      .clk(clk), .rst(rst), .we((op == BUS_WRITE) && sel_q),
      .idx(idx_q), .wdata(d_in), .rdata(rdata)
   );

   generate
      if (TEST2_GATES_BUS) begin : g_gate
         assign bus_allowed = test2_eff;
      end else begin : g_nogate
         assign bus_allowed = 1'b1;
      end
   endgenerate

   assign d_oe  = (op == BUS_READ) && sel_q && bus_allowed;
   assign d_out = d_oe ? rdata : '0;
endmodule

// File: rtl/psg_bus_front_chk.sv
module psg_bus_front_chk #(
   parameter int unsigned DATA_W          = 8,
   parameter int unsigned IDX_W           = 4,
   parameter int unsigned SEL_PATTERN     = 0,
   parameter bit          HAS_BC2         = 1'b1,
   parameter bit          HAS_TEST2       = 1'b1,
   parameter bit          TEST2_GATES_BUS = 1'b0
) (
   input logic              clk,
   input logic              rst,
   input logic              bdir,
   input logic              bc2,
   input logic              bc1,
   input logic              test2,
   input logic [DATA_W-1:0] d_in,
   input logic [DATA_W-1:0] d_out,
   input logic              d_oe,
   input logic              sel_q
);
   localparam int unsigned PAT_W = DATA_W - IDX_W;

   p_oe_only_read_r1: assert property (@(posedge clk) disable iff (rst)
      d_oe |-> (!bdir && bc1 && (bc2 || !HAS_BC2)));

   p_quiet_bus_r6: assert property (@(posedge clk) disable iff (rst)
      !d_oe |-> (d_out == '0));

   p_gate_test2_r7: assert property (@(posedge clk) disable iff (rst)
      (TEST2_GATES_BUS && HAS_TEST2 && !test2) |-> !d_oe);

   p_bad_latch_r4: assert property (@(posedge clk) disable iff (rst)
      (bdir && bc1 && (bc2 || !HAS_BC2) && (d_in[DATA_W-1:IDX_W] != SEL_PATTERN[PAT_W-1:0]))
      |=> !sel_q);

   p_reset_clear_r10: assert property (@(posedge clk)
      rst |=> !sel_q);

   p_oe_needs_sel_r4: assert property (@(posedge clk) disable iff (rst)
      d_oe |-> sel_q);
endmodule

bind psg_bus_front psg_bus_front_chk #(
   .DATA_W(DATA_W), .IDX_W(IDX_W), .SEL_PATTERN(SEL_PATTERN), .HAS_BC2(HAS_BC2),
   .HAS_TEST2(HAS_TEST2), .TEST2_GATES_BUS(TEST2_GATES_BUS)
) u_chk (
   .clk(clk), .rst(rst), .bdir(bdir), .bc2(bc2), .bc1(bc1), .test2(test2),
   .d_in(d_in), .d_out(d_out), .d_oe(d_oe), .sel_q(sel_q)
);

// File: tb/tb_psg_bus_front.sv
module tb_psg_bus_front;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic bdir = 0, bc2 = 0, bc1 = 0, a9_n = 0, a8 = 0, test2 = 1;
   logic [7:0] d_in = '0;
   logic [7:0] d_out;
   logic       d_oe;

   logic v_bdir = 0, v_bc2 = 0, v_bc1 = 0, v_a8 = 0;
   logic [7:0] v_d = '0;
   logic [7:0] v_out;
   logic       v_oe;

   int checks = 0;
   int failures = 0;
   bit armed = 0;
   bit done = 0;

   bit       m_sel = 0;
   int       m_idx = 0;
   int       m_mem [16];

   always #(CLK_PERIOD/2) clk = ~clk;

   psg_bus_front #(
      .SEL_PATTERN(15), .A8_ACTIVE_HIGH(1'b0), .TEST2_GATES_BUS(1'b1)
   ) dut (
      .clk(clk), .rst(rst), .bdir(bdir), .bc2(bc2), .bc1(bc1), .a9_n(a9_n),
      .a8(a8), .test2(test2), .d_in(d_in), .d_out(d_out), .d_oe(d_oe)
   );

   psg_bus_front #(
      .HAS_BC2(1'b0), .HAS_A9(1'b0), .HAS_TEST2(1'b0)
   ) dut_v (
      .clk(clk), .rst(rst), .bdir(v_bdir), .bc2(v_bc2), .bc1(v_bc1), .a9_n(1'b1),
      .a8(v_a8), .test2(1'b0), .d_in(v_d), .d_out(v_out), .d_oe(v_oe)
   );

   task automatic compare(input string tag, input logic oe, input logic [7:0] o,
                          input logic eoe, input logic [7:0] eo);
      checks++;
      if (oe !== eoe || o !== eo) begin
         failures++;
         $display("FAIL %s actual oe=%b out=%02h expected oe=%b out=%02h", tag, oe, o, eoe, eo);
      end
   endtask

   // one bus cycle on the main instance, compared against the model
   task automatic cyc(input logic r, input logic [2:0] code, input logic xa9,
                      input logic xa8, input logic xt2, input logic [7:0] d, input string tag);
      bit match;
      bit eoe;
      @(negedge clk);
      rst = r; {bdir, bc2, bc1} = code; a9_n = xa9; a8 = xa8; test2 = xt2; d_in = d;
      #1;
      if (armed) begin
         eoe = (code == 3'b011) && m_sel && xt2;
         compare(tag, d_oe, d_out, eoe, eoe ? 8'(m_mem[m_idx]) : 8'h00);
      end
      @(posedge clk);
      match = !xa9 && !xa8 && xt2 && (d[7:4] == 4'hF);
      if (r) begin
         m_sel = 0; m_idx = 0;
         foreach (m_mem[i]) m_mem[i] = 0;
         armed = 1;
      end else if (code == 3'b111) begin
         m_sel = match;
         if (match) m_idx = int'(d[3:0]);
      end else if (code == 3'b110 && m_sel) begin
         m_mem[m_idx] = int'(d);
      end
   endtask

   task automatic vstep(input logic [1:0] code, input logic xbc2, input logic xa8,
                        input logic [7:0] d, input logic eoe, input logic [7:0] eo,
                        input string tag);
      @(negedge clk);
      {v_bdir, v_bc1} = code; v_bc2 = xbc2; v_a8 = xa8; v_d = d;
      #1;
      compare(tag, v_oe, v_out, eoe, eo);
      @(posedge clk);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      cyc(1, 3'b000, 0, 0, 1, 8'h00, "R10");
      cyc(1, 3'b000, 0, 0, 1, 8'h00, "R10");
      cyc(0, 3'b011, 0, 0, 1, 8'h00, "R10");        // deselected after reset
      cyc(0, 3'b111, 0, 0, 1, 8'hF2, "R2");
      cyc(0, 3'b011, 0, 0, 1, 8'h00, "R10");        // register cleared
      cyc(0, 3'b110, 0, 0, 1, 8'h3C, "R5");
      cyc(0, 3'b011, 0, 0, 1, 8'h00, "R6");
      for (int c = 0; c < 8; c++) begin
         if (c != 3'b111 && c != 3'b110 && c != 3'b011)
            cyc(0, 3'(c), 0, 0, 1, 8'hF9, "R1");
      end
      cyc(0, 3'b011, 0, 0, 1, 8'h00, "R1");
      cyc(0, 3'b111, 0, 0, 1, 8'h02, "R3");         // pattern mismatch
      cyc(0, 3'b011, 0, 0, 1, 8'h00, "R4");
      cyc(0, 3'b110, 0, 0, 1, 8'h77, "R4");
      cyc(0, 3'b111, 0, 0, 1, 8'hF2, "R4");
      cyc(0, 3'b011, 0, 0, 1, 8'h00, "R4");
      cyc(0, 3'b111, 0, 1, 1, 8'hF2, "R3");         // a8 at inactive level
      cyc(0, 3'b011, 0, 0, 1, 8'h00, "R3");
      cyc(0, 3'b111, 1, 0, 1, 8'hF2, "R2");
      cyc(0, 3'b011, 0, 0, 1, 8'h00, "R2");
      cyc(0, 3'b111, 0, 0, 0, 8'hF2, "R2");
      cyc(0, 3'b011, 0, 0, 1, 8'h00, "R2");
      cyc(0, 3'b111, 0, 0, 1, 8'hF7, "R2");
      cyc(0, 3'b110, 0, 0, 1, 8'h11, "R5");
      cyc(0, 3'b011, 0, 0, 0, 8'h00, "R7");
      cyc(0, 3'b011, 0, 0, 1, 8'h00, "R7");
      for (int i = 0; i < 16; i++) begin
         cyc(0, 3'b111, 0, 0, 1, 8'(8'hF0 | i), "R2");
         cyc(0, 3'b110, 0, 0, 1, 8'(i * 13 + 5), "R5");
      end
      for (int i = 15; i >= 0; i--) begin
         cyc(0, 3'b111, 0, 0, 1, 8'(8'hF0 | i), "R2");
         cyc(0, 3'b011, 0, 0, 1, 8'h00, "R5");
      end
      cyc(1, 3'b000, 0, 0, 1, 8'h00, "R10");
      cyc(0, 3'b111, 0, 0, 1, 8'hF7, "R10");
      cyc(0, 3'b011, 0, 0, 1, 8'h00, "R10");

      // reduced-pin instance: bc2, a9_n and test2 held at inactive levels
      vstep(2'b11, 1'b0, 1'b1, 8'h03, 1'b0, 8'h00, "R8");
      vstep(2'b10, 1'b0, 1'b1, 8'h5A, 1'b0, 8'h00, "R8");
      vstep(2'b01, 1'b0, 1'b1, 8'h00, 1'b1, 8'h5A, "R9");
      vstep(2'b01, 1'b1, 1'b1, 8'h00, 1'b1, 8'h5A, "R8");
      vstep(2'b00, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, "R1");
      vstep(2'b11, 1'b0, 1'b0, 8'h03, 1'b0, 8'h00, "R3");
      vstep(2'b01, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, "R3");
      vstep(2'b11, 1'b0, 1'b1, 8'h13, 1'b0, 8'h00, "R2");
      vstep(2'b01, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, "R4");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule